// File: doc/BRIEF.md
# Pseudorandom-Dithered Pulse Density Modulator

This block turns a static multi-bit level into a single-bit pulse stream whose density of high cycles follows the level. Every clock it compares the held level with the current state of a maximal-length linear feedback shift register of the same width. The registered result drives a pin, for example an LED, so the average brightness tracks the level. Because the reference is pseudorandom and not a ramp, the high cycles are spread across the period instead of being grouped into one pulse.

The level comes from an asynchronous source such as switches. It passes through a two-flop synchronizer and a holding register before the compare. The compare result is registered once more before it reaches the pin. The whole path therefore has a single level of logic between flops, which suits clock rates in the 300 to 400 MHz range. The width is a parameter. Nine and twenty-four bits are the main cases, and the package carries feedback masks for several other widths.

Top module: `pdm_dither`

## Requirements
- R1: The output is high in a cycle exactly when the held level, taken as an unsigned number, is strictly greater than the generator state sampled on the edge before. An equal value gives low.
- R2: The generator never holds the all-zero state. Its period is 2^N−1. With a constant level, the output pattern repeats exactly every 2^N−1 cycles. The feedback bit is the XOR of the tap bits and is shifted into bit 0. For N=9 the taps are bits 8 and 4. For N=24 they are bits 23, 22, 21 and 16.
- R3: For a constant level L ≥ 1, any window of 2^N−1 consecutive cycles contains exactly L−1 high cycles.
- R4: A level of 0 keeps the output low in every cycle.
- R5: A full-scale level (all ones) gives a high output in all but one cycle of each period.
- R6: A change on the level input has no effect on the output before the fourth rising edge after the change. It takes effect at that fourth edge, after two synchronizer flops, the level register and the output register.
- R7: The reset is synchronous and active high. While it is asserted the output is low. For the first three rising edges after it is released the output stays low. The generator restarts from a nonzero seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all flops update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| level_i | input | WIDTH | Asynchronous unsigned density level |
| pdm_o | output | 1 | Registered pulse-density output |

## Verification
A level change is felt at the output on the fourth rising edge and no earlier. The bench therefore checks a low output at the falling edges after edges one to three, and looks for a high at the fourth or fifth edge, since one generator state in each period can mask a single cycle. After a reset edge the output is due low at the very next falling edge. Duty counts are taken only after eight settling cycles, over exactly 2^N−1 consecutive falling-edge samples. Any window of that length covers each nonzero generator state exactly once, so the expected count L−1 does not depend on the phase of the generator.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    // number of flops that resynchronise the level before it is held
    localparam int unsigned SYNC_DEPTH = 2;
    localparam int unsigned MAX_WIDTH  = 32;

    // Feedback mask (bit i set = bit i is a tap) for maximal-length
    // sequences. Bits are zero-based; the top bit is always a tap.
    function automatic logic [MAX_WIDTH-1:0] tap_mask(input int unsigned w);
        logic [MAX_WIDTH-1:0] m;
        m = '0;
        case (w)
            3:  begin m[2]  = 1'b1; m[1]  = 1'b1; end
            4:  begin m[3]  = 1'b1; m[2]  = 1'b1; end
            5:  begin m[4]  = 1'b1; m[2]  = 1'b1; end
            6:  begin m[5]  = 1'b1; m[4]  = 1'b1; end
            7:  begin m[6]  = 1'b1; m[5]  = 1'b1; end
            8:  begin m[7]  = 1'b1; m[5]  = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
            9:  begin m[8]  = 1'b1; m[4]  = 1'b1; end
            10: begin m[9]  = 1'b1; m[6]  = 1'b1; end
            11: begin m[10] = 1'b1; m[8]  = 1'b1; end
            12: begin m[11] = 1'b1; m[10] = 1'b1; m[9] = 1'b1; m[3] = 1'b1; end
            16: begin m[15] = 1'b1; m[14] = 1'b1; m[12] = 1'b1; m[3] = 1'b1; end
            24: begin m[23] = 1'b1; m[22] = 1'b1; m[21] = 1'b1; m[16] = 1'b1; end
            32: begin m[31] = 1'b1; m[21] = 1'b1; m[1] = 1'b1; m[0] = 1'b1; end
            default: begin m[0] = 1'b1; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pdm_lfsr.sv
module pdm_lfsr
    import pdm_pkg::*;
#(
    parameter int unsigned     WIDTH = 9,
    parameter logic [WIDTH-1:0] SEED = 1
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [MAX_WIDTH-1:0] MASK_FULL = tap_mask(WIDTH);
    localparam logic [WIDTH-1:0]     MASK      = MASK_FULL[WIDTH-1:0];

    typedef struct packed {
        logic [WIDTH-1:0] state;
    } lfsr_regs_t;

    lfsr_regs_t r_d, r_q;
    logic       fb;

    always_comb begin
        fb        = ^(r_q.state & MASK);
        r_d       = r_q;
        r_d.state = {r_q.state[WIDTH-2:0], fb};
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: SEED};
        else     r_q <= r_d;
    end

    assign state_o = r_q.state;

endmodule

// File: rtl/pdm_level_sync.sv
module pdm_level_sync
    import pdm_pkg::*;
#(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] level_o
);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]                 held;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        r_d.chain[0] = level_i;
        for (int i = 1; i < SYNC_DEPTH; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
        r_d.held     = r_q.chain[SYNC_DEPTH-1];
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign level_o = r_q.held;

endmodule

// File: rtl/pdm_compare.sv
module pdm_compare #(
    parameter int unsigned WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] seq_i,
    output logic             hit_o
);

    typedef struct packed {
        logic hit;
    } cmp_regs_t;

    cmp_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.hit = (level_i > seq_i);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign hit_o = r_q.hit;

endmodule

// File: rtl/pdm_dither.sv
module pdm_dither
    import pdm_pkg::*;
#(
    parameter int unsigned WIDTH = 9,
    parameter int unsigned SEED  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic             pdm_o
);

    localparam logic [WIDTH-1:0] SEED_RAW = WIDTH'(SEED);
    localparam logic [WIDTH-1:0] SEED_NZ  = (SEED_RAW == '0) ? WIDTH'(1) : SEED_RAW;

    logic [WIDTH-1:0] seq_w;
    logic [WIDTH-1:0] level_w;

    pdm_level_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .level_i (level_i),
        .level_o (level_w)
    );

    pdm_lfsr #(.WIDTH(WIDTH), .SEED(SEED_NZ)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .state_o (seq_w)
    );

    pdm_compare #(.WIDTH(WIDTH)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .level_i (level_w),
        .seq_i   (seq_w),
        .hit_o   (pdm_o)
    );

endmodule

// File: rtl/pdm_dither_chk.sv
module pdm_dither_chk #(
    parameter int unsigned WIDTH = 9
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] level_i,
    input logic             pdm_o,
    input logic [WIDTH-1:0] seq,
    input logic [WIDTH-1:0] level_q
);

    // cycles since reset release, saturating
    logic [2:0] cnt;
    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt != 3'd7) cnt <= cnt + 3'd1;
    end

    assert_seq_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
        seq != '0);

    assert_seq_moves_R2: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd1) |-> (seq != $past(seq)));

    assert_level_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd3) |-> (level_q == $past(level_i, 3)));

    assert_zero_level_low_R4: assert property (@(posedge clk) disable iff (rst)
        ((cnt >= 3'd1) && ($past(level_q) == '0)) |-> !pdm_o);

    assert_startup_low_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt <= 3'd3) |-> !pdm_o);

endmodule

bind pdm_dither pdm_dither_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .level_i (level_i),
    .pdm_o   (pdm_o),
    .seq     (seq_w),
    .level_q (level_w)
);

// File: tb/sim_pdm_dither.sv
`timescale 1ns/1ps
module sim_pdm_dither;

    localparam int W   = 9;
    localparam int PER = (1 << W) - 1;
    localparam logic [W-1:0] FULL = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] level = '0;
    logic         pdm;
    int           n_chk = 0;
    int           n_fail = 0;

    always #2.5 clk = ~clk;

    pdm_dither #(.WIDTH(W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .level_i (level),
        .pdm_o   (pdm)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // R7: low during reset and for three edges after release
    task automatic t_reset();
        rst   = 1'b1;
        level = FULL;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pdm == 1'b0, "R7 in reset", int'(pdm), 0);
        end
        rst = 1'b0;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(pdm == 1'b0, "R7 after release", int'(pdm), 0);
        end
    endtask

    // R1 R3 R4 R5: high count over one full period
    task automatic t_duty(input logic [W-1:0] lv);
        int ones = 0;
        int exp;
        level = lv;
        repeat (8) @(negedge clk);
        for (int k = 0; k < PER; k++) begin
            @(negedge clk);
            ones += int'(pdm);
        end
        exp = (lv == '0) ? 0 : int'(lv) - 1;
        if (lv == '0)        check(ones == exp, "R4 zero level", ones, exp);
        else if (lv == FULL) check(ones == exp, "R5 full scale", ones, exp);
        else                 check(ones == exp, "R1 R3 duty count", ones, exp);
    endtask

    // R2: pattern repeats every period and is not trivial
    task automatic t_period();
        logic [PER-1:0] a, b;
        level = 9'd200;
        repeat (8) @(negedge clk);
        for (int k = 0; k < PER; k++) begin @(negedge clk); a[k] = pdm; end
        for (int k = 0; k < PER; k++) begin @(negedge clk); b[k] = pdm; end
        check(a == b, "R2 period repeat", $countones(a ^ b), 0);
        check($countones(a) == 199, "R2 one period count", $countones(a), 199);
    endtask

    // R6: level change lands on the fourth edge
    task automatic t_latency();
        bit h4, h5;
        level = '0;
        repeat (8) @(negedge clk);
        level = FULL;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            check(pdm == 1'b0, "R6 rise not early", int'(pdm), 0);
        end
        @(negedge clk); h4 = pdm;
        @(negedge clk); h5 = pdm;
        check(h4 | h5, "R6 rise by edge 4 or 5", int'(h4 | h5), 1);
        level = '0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        check(pdm == 1'b0, "R6 fall at edge 4", int'(pdm), 0);
        @(negedge clk);
        check(pdm == 1'b0, "R6 fall at edge 5", int'(pdm), 0);
    endtask

    // R7: reset in the middle of a run
    task automatic t_mid_reset();
        level = FULL;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pdm == 1'b0, "R7 mid-run reset", int'(pdm), 0);
        end
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(pdm == 1'b0, "R7 mid-run release", int'(pdm), 0);
        end
    endtask

    initial begin
        t_reset();
        t_duty(9'd0);
        t_duty(9'd1);
        t_duty(9'd2);
        t_duty(9'd5);
        t_duty(9'd256);
        t_duty(9'd510);
        t_duty(FULL);
        t_period();
        t_latency();
        t_mid_reset();
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
        summary();
        $finish;
    end

endmodule